// File: doc/BRIEF.md
# Scan Register with Update Latch

This block is a serial scan register for a test access port. The same module serves as the instruction register or as a test data register, selected by a parameter. It has two storage stages. The shift stage is loaded in parallel on a capture strobe, and on a shift strobe it moves toward the serial output one bit per clock. The update latch holds the value presented on the parallel output. That value is replaced only when an update strobe arrives.

The capture, shift and update strobes and the reset strobe come from the access-port state machine. The state machine is outside this block. The shift stage is written on the rising edge of the test clock. The update latch is written on the falling edge, so the parallel output stays frozen for the whole of a capture, shift or pause sequence. In instruction mode, the value released at update is the current instruction, and the reset value is the all-ones bypass code.

Top module: `tap_scan_reg`

## Requirements
- R1: When `cap_en` is high at a rising edge, the shift stage takes the conditioned capture value at that edge. In data mode the conditioned value is `cap_in` unchanged.
- R2: When `shift_en` is high and `cap_en` is low at a rising edge, the shift stage moves one place toward bit 0. `ser_in` enters the top bit and `ser_out` presents bit 0, so the least significant bit leaves first.
- R3: At a rising edge where neither `cap_en` nor `shift_en` is high (pause and exit states), the shift stage and `ser_out` keep their value.
- R4: When `upd_en` is high at a falling edge, `par_out` takes the shift-stage contents present at that edge.
- R5: `par_out` changes at no falling edge other than one with `upd_en` or `rst` high. This covers every capture, shift and pause cycle.
- R6: When `rst` is high, the falling edge loads `par_out` with `RESET_VAL` (all ones by default) and the rising edge clears the shift stage to zero.
- R7: If `cap_en` and `shift_en` are both high at a rising edge, the capture wins and no shift takes place.
- R8: In instruction mode, the conditioned capture value has bits [1:0] forced to binary 01 and bits [WIDTH-1:2] taken from `cap_in`.
- R9: If `upd_en` and `shift_en` are high in the same cycle, `par_out` receives the contents from before that cycle's shift, because the falling edge comes before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; shift stage on rising edge, update latch on falling edge |
| rst | input | 1 | Synchronous active-high reset strobe |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| cap_in | input | WIDTH | Parallel capture value |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, bit 0 of the shift stage |
| par_out | output | WIDTH | Latched parallel output |

## Verification
The assertions assume three things about the strobes. They are stable across each half clock in which they are sampled. Each one reaches this block only as a synchronous level, never as a glitch. The reset strobe is raised before the first clock edge of interest. The bench meets these assumptions by changing every input one nanosecond after a rising edge, which is well before the falling edge that the update latch samples. It also holds the reset strobe high from time zero. Beyond the mutually exclusive sequences an access-port state machine would produce, the stimulus also drives the overlapping cases on purpose: capture together with shift, and update together with shift. This exercises the defined priority and the edge ordering.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Selects which role the scan register plays.
  typedef enum logic {
    SCAN_DATA  = 1'b0,
    SCAN_INSTR = 1'b1
  } scan_kind_e;

  // Fixed marker placed in the low capture bits of an instruction register.
  localparam logic [1:0] INSTR_CAPTURE_TAG = 2'b01;
endpackage

// File: rtl/scan_capture_cond.sv
module scan_capture_cond #(
  parameter int                   WIDTH = 8,
  parameter scan_pkg::scan_kind_e KIND  = scan_pkg::SCAN_INSTR
) (
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] cond_out
);
  // Instruction role: the two lowest bits always read back the fixed tag.
  generate
    if (KIND == scan_pkg::SCAN_INSTR && WIDTH > 2) begin : g_instr_wide
      assign cond_out = {raw_in[WIDTH-1:2], scan_pkg::INSTR_CAPTURE_TAG};
    end else if (KIND == scan_pkg::SCAN_INSTR) begin : g_instr_narrow
      assign cond_out = scan_pkg::INSTR_CAPTURE_TAG[WIDTH-1:0];
    end else begin : g_data
      assign cond_out = raw_in;
    end
  endgenerate

  // R8: the tag is present whenever the instruction role is chosen
  always_comb begin
    if (KIND == scan_pkg::SCAN_INSTR && WIDTH >= 2)
      assert_instr_tag_R8: assert (cond_out[1:0] == scan_pkg::INSTR_CAPTURE_TAG || $isunknown(raw_in));
  end
endmodule

// File: rtl/scan_shift_stage.sv
module scan_shift_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] cap_val,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stage_q,
  output logic             ser_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (cap_en) begin
      stage_q <= cap_val;
    end else if (shift_en) begin
      stage_q <= {ser_in, stage_q[WIDTH-1:1]};
    end
  end

  assign ser_out = stage_q[0];

  // R1, R7: capture loads the conditioned value, even alongside shift
  assert_capture_load_R1: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> stage_q == $past(cap_val));

  // R2: a lone shift moves one place toward the serial output
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> ser_out == $past(stage_q[1 % WIDTH]) || WIDTH == 1);

  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> stage_q[WIDTH-1] == $past(ser_in));

  // R3: no strobe means the stage holds
  assert_pause_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !shift_en) |=> $stable(stage_q));
endmodule

// File: rtl/scan_update_latch.sv
module scan_update_latch #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] stage_in,
  output logic [WIDTH-1:0] par_q
);
  // Written on the falling edge: mid-cycle of the update state.
  always_ff @(negedge clk) begin
    if (rst) begin
      par_q <= RESET_VAL;
    end else if (upd_en) begin
      par_q <= stage_in;
    end
  end

  // R4: update transfers the stage contents
  assert_update_copy_R4: assert property (@(negedge clk) disable iff (rst)
    upd_en |=> par_q == $past(stage_in));

  // R5: no update means a frozen parallel output
  assert_output_frozen_R5: assert property (@(negedge clk) disable iff (rst)
    !upd_en |=> $stable(par_q));
endmodule

// File: rtl/tap_scan_reg.sv
module tap_scan_reg #(
  parameter int                   WIDTH     = 8,
  parameter scan_pkg::scan_kind_e KIND      = scan_pkg::SCAN_INSTR,
  parameter logic [WIDTH-1:0]     RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] cap_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_out
);
  logic [WIDTH-1:0] cap_cond;
  logic [WIDTH-1:0] stage_q;

  scan_capture_cond #(.WIDTH(WIDTH), .KIND(KIND)) u_cond (
    .raw_in   (cap_in),
    .cond_out (cap_cond)
  );

  scan_shift_stage #(.WIDTH(WIDTH)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .cap_val  (cap_cond),
    .ser_in   (ser_in),
    .stage_q  (stage_q),
    .ser_out  (ser_out)
  );

  scan_update_latch #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (upd_en),
    .stage_in (stage_q),
    .par_q    (par_out)
  );

  // R6: a reset seen at the falling edge leaves the default on the output
  logic rst_at_fall;
  always_ff @(negedge clk) rst_at_fall <= rst;

  always @(posedge clk) begin
    if (rst_at_fall === 1'b1)
      assert_reset_value_R6: assert (par_out == RESET_VAL);
  end

  // R6: the stage leaves reset cleared
  assert_stage_clear_R6: assert property (@(posedge clk)
    rst |=> stage_q == '0);

  // R9: update alongside shift publishes the pre-shift contents
  assert_update_before_shift_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_en && shift_en && !cap_en) |=> par_out == {$past(stage_q)});
endmodule

// File: tb/tap_scan_reg_bench.sv
module tap_scan_reg_bench;
  localparam int W = 8;
  localparam logic [W-1:0] RST_V = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, ser_in = 1'b0;
  logic [W-1:0] cap_in = '0;
  logic ser_out;
  logic [W-1:0] par_out;

  always #2 clk = ~clk;

  tap_scan_reg #(.WIDTH(W), .KIND(scan_pkg::SCAN_INSTR), .RESET_VAL(RST_V)) u_tap_scan_reg (
    .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
    .cap_in(cap_in), .ser_in(ser_in), .ser_out(ser_out), .par_out(par_out)
  );

  typedef struct {
    logic         chk_ser;
    logic         ser;
    logic [W-1:0] par;
    string        req;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_sr, m_par;
  logic m_valid = 1'b0;
  bit done = 0;

  // Capture conditioning per R8, written from the requirement.
  function automatic logic [W-1:0] instr_cap(input logic [W-1:0] v);
    return {v[W-1:2], 2'b01};
  endfunction

  // Drive one cycle, predict the outputs seen after this cycle's falling edge.
  task automatic step(input logic r, input logic c, input logic s, input logic u,
                      input logic d, input logic [W-1:0] cd, input string req);
    exp_t e;
    rst = r; cap_en = c; shift_en = s; upd_en = u; ser_in = d; cap_in = cd;
    if (r) m_par = RST_V;
    else if (u) m_par = m_sr;
    e.chk_ser = m_valid; e.ser = m_sr[0]; e.par = m_par; e.req = req;
    q.push_back(e);
    if (r) begin m_sr = '0; m_valid = 1'b1; end
    else if (c) m_sr = instr_cap(cd);
    else if (s) m_sr = {d, m_sr[W-1:1]};
    @(posedge clk); #1;
  endtask

  // Monitor: compares after every falling edge.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if ((e.chk_ser && ser_out !== e.ser) || par_out !== e.par) begin
          n_bad++;
          $display("FAIL %s: ser_out=%b par_out=%h expected ser_out=%b par_out=%h",
                   e.req, ser_out, par_out, e.ser, e.par);
        end
      end
    end
  end

  initial begin
    @(posedge clk); #1;
    // R6, R5: reset state and bypass default
    step(1, 0, 0, 0, 0, '0, "R6");
    step(1, 0, 0, 0, 0, '0, "R6");
    step(0, 0, 0, 0, 0, '0, "R6");
    // R1, R8: capture with tag forced into bits 1:0
    step(0, 1, 0, 0, 0, 8'hA6, "R8");
    step(0, 0, 0, 0, 0, '0, "R1");
    // R2: shift out LSB first while shifting in a pattern; R5 output frozen
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, i[0], '0, "R2");
    // R3: pause holds stage; R5 still frozen
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 8'hFF, "R3");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, ~i[1], '0, "R2");
    // R4: update publishes stage
    step(0, 0, 0, 1, 0, '0, "R4");
    step(0, 0, 0, 0, 0, '0, "R5");
    // R7: capture wins over shift
    step(0, 1, 1, 0, 1, 8'h3C, "R7");
    step(0, 0, 0, 0, 0, '0, "R7");
    step(0, 0, 0, 1, 0, '0, "R7");
    // R9: update with shift uses pre-shift contents
    step(0, 0, 1, 0, 1, '0, "R9");
    step(0, 0, 1, 1, 0, '0, "R9");
    step(0, 0, 0, 0, 0, '0, "R9");
    step(0, 0, 0, 1, 0, '0, "R9");
    // R1: a second capture pattern, R5 frozen across capture
    step(0, 1, 0, 0, 0, 8'h5B, "R1");
    for (int i = 0; i < W; i++) step(0, 0, 1, 0, 1'b0, '0, "R2");
    step(0, 0, 0, 1, 0, '0, "R4");
    // R6: mid-stream reset restores default
    step(0, 1, 0, 0, 0, 8'h80, "R6");
    step(1, 0, 0, 0, 0, '0, "R6");
    step(0, 0, 0, 0, 0, '0, "R6");
    step(0, 0, 0, 1, 0, '0, "R6");
    step(0, 0, 0, 0, 0, '0, "R5");
    @(negedge clk); #2;
    done = 1;
  end

  initial begin
    for (int t = 0; t < 5000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule